// File: doc/BRIEF.md
# TMDS Lane Symbol Encoder

This block turns one colour lane of a minimised-transition differential video link into a stream of 10-bit line symbols, one per pixel clock. A link uses three copies, one for each of red, green and blue, next to a separate clock lane. The lane that carries blue also carries the horizontal and vertical sync bits as its two control inputs.

While the data-enable input is high, the block codes the input byte in two steps. The first step builds a chained XOR or XNOR word that keeps transitions low and records the chosen chain in bit 8. The second step may invert the low byte to steer a signed running disparity back toward zero, and flags the inversion in bit 9. While data-enable is low, the block sends one of four fixed control tokens and clears the disparity.

The serialiser, the output buffers and the packet-period coding sit outside this block.

Top module: `tmds_lane_encoder`

## Requirements
- R1: The symbol output is registered. A symbol shows on `sym_o` one clock after the inputs that produced it were sampled. While reset is held, `sym_o` is 10'b1101010100.
- R2: With `de_i` low, the symbol depends on `ctrl_i` (bit 0 = hsync, bit 1 = vsync): 00→1101010100, 01→0010101011, 10→0101010100, 11→1010101011.
- R3: The XNOR chain is used when the byte has more than four ones, or exactly four ones and bit 0 at 0. Otherwise the XOR chain is used. Symbol bit 8 is 1 for XOR and 0 for XNOR.
- R4: The intermediate word has q[0] = d[0]. For i from 1 to 7, q[i] = q[i-1] XOR d[i], or its complement when the XNOR chain is used.
- R5: When the running disparity is zero, or the intermediate low byte has four ones, the low byte is inverted exactly when bit 8 is 0, and bit 9 equals NOT bit 8.
- R6: Otherwise, the low byte is inverted and bit 9 is 1 when the sign of the running disparity equals the sign of the byte's ones-minus-zeros. If the signs differ, the byte is sent as is and bit 9 is 0.
- R7: The running disparity is the sum of ones-minus-zeros over the data symbols sent since `de_i` was last low. A control period resets it to zero.
- R8: Over any unbroken run of data symbols, the accumulated ones-minus-zeros of the emitted 10-bit symbols stays within ±8.
- R9: Every data symbol decodes back to its input byte: first undo the inversion flagged by bit 9, then undo the chain selected by bit 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| de_i | input | 1 | High during active video |
| ctrl_i | input | 2 | Control bits sent during blanking (bit 0 hsync, bit 1 vsync) |
| data_i | input | 8 | Pixel byte for this lane |
| sym_o | output | 10 | Coded line symbol |

## Verification
A corrupted disparity register does not change the symbol at once. It first shows on the next data symbol whose low byte is unbalanced, as a wrong bit 9 and a complemented low byte. After that, the accumulated disparity on the line drifts past ±8 within a few symbols. A wrong chain choice or a broken chain shows on the very next data symbol, as a wrong bit 8 or a byte that does not decode back. A control period that fails to clear the disparity shows on the first data symbol after blanking. The bench therefore compares every symbol against an independent model and tracks the line's accumulated disparity symbol by symbol.

// File: rtl/tmds_enc_pkg.sv
package tmds_enc_pkg;
  localparam int DATA_W  = 8;
  localparam int SYM_W   = DATA_W + 2;
  localparam int POP_W   = $clog2(DATA_W + 1);
  localparam int DISP_W  = $clog2(DATA_W + 2) + 2;
  localparam int CTRL_W  = 2;

  localparam logic [SYM_W-1:0] TOK_00 = 10'b1101010100;
  localparam logic [SYM_W-1:0] TOK_01 = 10'b0010101011;
  localparam logic [SYM_W-1:0] TOK_10 = 10'b0101010100;
  localparam logic [SYM_W-1:0] TOK_11 = 10'b1010101011;

  typedef logic signed [DISP_W-1:0] disp_t;
endpackage

// File: rtl/tmds_ones_count.sv
module tmds_ones_count #(
  parameter int W   = 8,
  parameter int OUT = $clog2(W + 1)
) (
  input  logic [W-1:0]   vec_i,
  output logic [OUT-1:0] ones_o
);
  always_comb begin
    ones_o = '0;
    for (int i = 0; i < W; i++) begin
      ones_o = ones_o + OUT'(vec_i[i]);
    end
  end
endmodule

// File: rtl/tmds_xition_stage.sv
module tmds_xition_stage
  import tmds_enc_pkg::*;
(
  input  logic              use_xnor_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W:0]   qm_o
);
  // Chain starts at bit 0 and runs upward; XNOR is XOR followed by a flip.
  assign qm_o[0] = data_i[0];
  for (genvar i = 1; i < DATA_W; i++) begin : g_chain
    assign qm_o[i] = qm_o[i-1] ^ data_i[i] ^ use_xnor_i;
  end
  assign qm_o[DATA_W] = ~use_xnor_i;
endmodule

// File: rtl/tmds_ctrl_token.sv
module tmds_ctrl_token
  import tmds_enc_pkg::*;
(
  input  logic [CTRL_W-1:0] ctrl_i,
  output logic [SYM_W-1:0]  tok_o
);
  always_comb begin
    unique case (ctrl_i)
      2'b00:   tok_o = TOK_00;
      2'b01:   tok_o = TOK_01;
      2'b10:   tok_o = TOK_10;
      default: tok_o = TOK_11;
    endcase
  end
endmodule

// File: rtl/tmds_dc_balancer.sv
module tmds_dc_balancer
  import tmds_enc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             data_en_i,
  input  logic [DATA_W:0]  qm_i,
  input  logic [POP_W-1:0] qm_ones_i,
  output logic [SYM_W-1:0] sym_o
);
  disp_t disp_q, disp_d;
  disp_t imbal, delta;
  logic  invert;

  always_comb begin
    imbal = disp_t'(qm_ones_i) * disp_t'(2) - disp_t'(DATA_W);
    if (disp_q == '0 || imbal == '0) begin
      invert = ~qm_i[DATA_W];
    end else begin
      invert = (disp_q[DISP_W-1] == imbal[DISP_W-1]);
    end
    sym_o = {invert, qm_i[DATA_W], invert ? ~qm_i[DATA_W-1:0] : qm_i[DATA_W-1:0]};
    // Disparity contributed by the full symbol: byte, mode bit, flag bit.
    delta = (invert ? -imbal : imbal)
          + (qm_i[DATA_W] ? disp_t'(1) : disp_t'(-1))
          + (invert ? disp_t'(1) : disp_t'(-1));
    disp_d = data_en_i ? disp_q + delta : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) disp_q <= '0;
    else        disp_q <= disp_d;
  end

  assert_disp_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_q <= disp_t'(DATA_W)) && (disp_q >= -disp_t'(DATA_W)));

  assert_disp_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !data_en_i |=> disp_q == '0);
endmodule

// File: rtl/tmds_lane_encoder.sv
module tmds_lane_encoder
  import tmds_enc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              de_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [SYM_W-1:0]  sym_o
);
  logic [POP_W-1:0] data_ones, qm_ones;
  logic             use_xnor;
  logic [DATA_W:0]  qm;
  logic [SYM_W-1:0] data_sym, ctrl_sym, sym_d, sym_q;

  tmds_ones_count #(.W(DATA_W), .OUT(POP_W)) u_cnt_data (
    .vec_i(data_i), .ones_o(data_ones));

  always_comb begin
    use_xnor = (data_ones > POP_W'(DATA_W/2)) ||
               ((data_ones == POP_W'(DATA_W/2)) && !data_i[0]);
  end

  tmds_xition_stage u_xition (
    .use_xnor_i(use_xnor), .data_i(data_i), .qm_o(qm));

  tmds_ones_count #(.W(DATA_W), .OUT(POP_W)) u_cnt_qm (
    .vec_i(qm[DATA_W-1:0]), .ones_o(qm_ones));

  tmds_dc_balancer u_balance (
    .clk(clk), .rst_n(rst_n), .data_en_i(de_i),
    .qm_i(qm), .qm_ones_i(qm_ones), .sym_o(data_sym));

  tmds_ctrl_token u_token (.ctrl_i(ctrl_i), .tok_o(ctrl_sym));

  always_comb sym_d = de_i ? data_sym : ctrl_sym;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sym_q <= TOK_00;
    else        sym_q <= sym_d;
  end

  assign sym_o = sym_q;

  // Independent decoder used only by the checks below.
  function automatic logic [DATA_W-1:0] undo_sym(input logic [SYM_W-1:0] s);
    logic [DATA_W-1:0] w, d;
    w = s[DATA_W+1] ? ~s[DATA_W-1:0] : s[DATA_W-1:0];
    d[0] = w[0];
    for (int i = 1; i < DATA_W; i++) d[i] = s[DATA_W] ? (w[i] ^ w[i-1]) : ~(w[i] ^ w[i-1]);
    return d;
  endfunction

  assert_decode_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(de_i) |-> undo_sym(sym_o) == $past(data_i));

  assert_xnor_choice_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(de_i) && !sym_o[DATA_W] |-> $countones($past(data_i)) >= DATA_W/2);

  assert_ctrl_token_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(de_i) |->
      ((sym_o == TOK_00) || (sym_o == TOK_01) || (sym_o == TOK_10) || (sym_o == TOK_11)));
endmodule

// File: tb/tmds_lane_encoder_tb.sv
module tmds_lane_encoder_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       de_i;
  logic [1:0] ctrl_i;
  logic [7:0] data_i;
  logic [9:0] sym_o;

  always #10 clk = ~clk;

  tmds_lane_encoder u_dut (
    .clk(clk), .rst_n(rst_n), .de_i(de_i), .ctrl_i(ctrl_i),
    .data_i(data_i), .sym_o(sym_o));

  int checks = 0;
  int fails  = 0;
  int ref_disp = 0;
  bit ref_prev_de = 1'b0;
  int line_disp = 0;
  bit done = 1'b0;

  logic [9:0] exp_q[$];
  string      tag_q[$];
  logic [8:0] info_q[$];

  task automatic drive(input bit de, input logic [1:0] c, input logic [7:0] d, input string tag);
    logic [9:0] e;
    logic [7:0] qm;
    string t;
    bit xn, inv;
    int b;
    @(negedge clk);
    de_i = de; ctrl_i = c; data_i = d;
    if (!de) begin
      case (c)
        2'b00: e = 10'b1101010100;
        2'b01: e = 10'b0010101011;
        2'b10: e = 10'b0101010100;
        default: e = 10'b1010101011;
      endcase
      t = "R2";
      ref_disp = 0;
    end else begin
      xn = ($countones(d) > 4) || ($countones(d) == 4 && d[0] == 1'b0);
      qm[0] = d[0];
      for (int i = 1; i < 8; i++) qm[i] = xn ? ~(qm[i-1] ^ d[i]) : (qm[i-1] ^ d[i]);
      b = 2 * $countones(qm) - 8;
      if (ref_disp == 0 || b == 0) begin
        inv = xn; ref_disp += xn ? -b : b; t = "R5";
      end else if ((ref_disp > 0 && b > 0) || (ref_disp < 0 && b < 0)) begin
        inv = 1'b1; ref_disp += (xn ? 0 : 2) - b; t = "R6";
      end else begin
        inv = 1'b0; ref_disp += b - (xn ? 2 : 0); t = "R6";
      end
      e = {inv, ~xn, inv ? ~qm : qm};
      if (!ref_prev_de) t = "R7";
    end
    ref_prev_de = de;
    if (tag != "") t = tag;
    @(posedge clk);
    #1;
    exp_q.push_back(e); tag_q.push_back(t); info_q.push_back({de, d});
  endtask

  function automatic logic [7:0] tb_decode(input logic [9:0] s);
    logic [7:0] w, d;
    w = s[9] ? ~s[7:0] : s[7:0];
    d[0] = w[0];
    for (int i = 1; i < 8; i++) d[i] = s[8] ? (w[i] ^ w[i-1]) : ~(w[i] ^ w[i-1]);
    return d;
  endfunction

  // Monitor: compares each registered symbol one edge after its inputs.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [9:0] e;
      logic [8:0] inf;
      string t;
      e = exp_q.pop_front(); t = tag_q.pop_front(); inf = info_q.pop_front();
      checks++;
      if (sym_o !== e) begin
        fails++;
        $display("FAIL %s symbol actual=%b expected=%b", t, sym_o, e);
      end
      if (inf[8]) begin
        line_disp += 2 * $countones(sym_o) - 10;
        checks++;
        if (line_disp > 8 || line_disp < -8) begin
          fails++;
          $display("FAIL R8 line disparity actual=%0d expected within +-8", line_disp);
        end
        checks++;
        if (tb_decode(sym_o) !== inf[7:0]) begin
          fails++;
          $display("FAIL R9 decoded actual=%h expected=%h", tb_decode(sym_o), inf[7:0]);
        end
      end else begin
        line_disp = 0;
      end
    end
  end

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; de_i = 1'b0; ctrl_i = 2'b00; data_i = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (sym_o !== 10'b1101010100) begin
      fails++;
      $display("FAIL R1 reset symbol actual=%b expected=%b", sym_o, 10'b1101010100);
    end
    rst_n = 1'b1;
    drive(1'b0, 2'b11, 8'h00, "R1");
    drive(1'b0, 2'b00, 8'h00, "");
    drive(1'b0, 2'b01, 8'h00, "");
    drive(1'b0, 2'b10, 8'h00, "");
    drive(1'b0, 2'b11, 8'h00, "");
    // Chain choice corners: 4 ones with bit0 set/clear, all ones, none.
    drive(1'b1, 2'b00, 8'h0F, "R3");
    drive(1'b1, 2'b00, 8'hF0, "R3");
    drive(1'b1, 2'b00, 8'hFF, "R3");
    drive(1'b1, 2'b00, 8'h00, "R4");
    drive(1'b1, 2'b00, 8'h01, "R4");
    drive(1'b1, 2'b00, 8'hA5, "R4");
    drive(1'b1, 2'b00, 8'h10, "");
    drive(1'b1, 2'b00, 8'h10, "");
    drive(1'b1, 2'b00, 8'hEF, "");
    // Blanking then data: disparity must restart from zero.
    drive(1'b0, 2'b01, 8'h00, "");
    drive(1'b1, 2'b00, 8'h10, "R7");
    drive(1'b1, 2'b00, 8'h10, "");
    // Lines with short blanking.
    for (int l = 0; l < 60; l++) begin
      for (int p = 0; p < 40; p++) drive(1'b1, 2'b00, 8'($urandom), "");
      for (int p = 0; p < 4; p++) drive(1'b0, 2'($urandom), 8'h00, "");
    end
    // Long unbroken run for the disparity bound.
    for (int p = 0; p < 3000; p++) drive(1'b1, 2'b00, 8'($urandom), "");
    for (int p = 0; p < 200; p++) drive(1'b1, 2'b00, ((p % 3) == 0) ? 8'h10 : 8'hFE, "");
    drive(1'b0, 2'b00, 8'h00, "");
    while (exp_q.size() > 0) @(posedge clk);
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule